// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port, word-organised memory that sits behind a fully registered command interface. A command is captured on one rising edge of the clock and its data transfer happens exactly two enabled edges later. Write data arrives on the same delay as read data leaves, so a read may follow a write, or a write a read, on consecutive commands with no idle cycle between them.

A command is a load, an advance, or a deselect. A load starts an access at the address on the port. It needs the load strobe low and all three chip selects true. An advance continues the current burst at an address supplied by a separate burst sequencer. The core presents its current burst address on `cur_addr`, and the sequencer returns the next address on `adv_addr`. A deselect ends any burst. Pulling the active-low clock enable high freezes the whole block for that edge.

The bidirectional data bus is modelled as a data-in bus, a registered data-out bus and a drive flag that is high only while read data is on the bus. The word has four 9-bit lanes, and each lane has its own active-low write enable.

Top module: `zbt_sram_core`

## Requirements
- R1: A load happens on an enabled edge with `load_n` low and the chips selected, meaning `cs_a_n`=0, `cs_b_n`=0 and `cs_c`=1. It captures `addr` and the direction (`rd_wrn` 1 = read, 0 = write). `cur_addr` shows the captured address after that edge.
- R2: The data phase of a command is the second enabled edge after its command edge. A write stores `wdata` sampled at that edge. A read loads `rdata` at that edge and sets `rdata_oe` to 1. Commands may be issued on every cycle.
- R3: An edge with `cke_n` high has no effect. `rdata`, `rdata_oe`, `cur_addr`, the pipeline and the array all keep their values, and that edge does not count towards any data phase.
- R4: An enabled edge with `load_n` low and any chip select false is a deselect. It ends the current burst, and `rdata_oe` is 0 after its data-phase edge. Transfers issued earlier still complete.
- R5: An enabled edge with `load_n` high while a burst is active is an advance. It accesses `adv_addr` in the direction captured at the load and ignores `rd_wrn`. `cur_addr` then becomes `adv_addr`.
- R6: An enabled edge with `load_n` high and no active burst is a no-op. `rdata_oe` is 0 after its data-phase edge.
- R7: Lane k covers word bits 9k to 9k+8. `lane_we_n[k]` = 0, sampled with a write or burst-write command, writes that lane at the data phase. Any set of lanes may be written together, and disabled lanes keep their old contents.
- R8: `lane_we_n` and `wdata` have no effect on reads. During the data phase of a write, `rdata_oe` is 0.
- R9: After reset `rdata_oe` is 0 and no burst is active.
- R10: A read issued two cycles after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; high freezes the edge |
| cs_a_n | input | 1 | Active-low chip select A |
| cs_b_n | input | 1 | Active-low chip select B |
| cs_c | input | 1 | Active-high chip select C |
| load_n | input | 1 | Low: load or deselect; high: advance burst |
| rd_wrn | input | 1 | Direction at load: 1 read, 0 write |
| lane_we_n | input | LANES | Active-low per-lane write enables |
| addr | input | ADDR_W | Load address |
| adv_addr | input | ADDR_W | Next burst address from the sequencer |
| cur_addr | output | ADDR_W | Current burst address for the sequencer |
| wdata | input | LANES*LANE_W | Write data, sampled at the data phase |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_oe | output | 1 | High while read data is driven |

## Verification
Two events can fall on the same enabled edge: the data phase of an earlier command and the capture of a new one. The bench provokes this with alternating writes and reads to different addresses issued on consecutive cycles, and with a read placed two cycles after a write to the same address. It judges the result from the read word and the drive flag seen one half-cycle after each data-phase edge. A second overlap is a clock-enable freeze that lands between a command and its data phase. Here the check is that the phase slips by exactly one cycle and that the frozen write attempt leaves the array unchanged.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned LANE_W_DEF = 9;

  // Expand active-low lane enables into a per-bit write mask.
  function automatic logic [LANES_DEF*LANE_W_DEF-1:0] lane_mask(input logic [LANES_DEF-1:0] we_n);
    logic [LANES_DEF*LANE_W_DEF-1:0] m;
    for (int k = 0; k < LANES_DEF; k++)
      m[k*LANE_W_DEF +: LANE_W_DEF] = {LANE_W_DEF{~we_n[k]}};
    return m;
  endfunction
endpackage

// File: rtl/zbt_cmd_decode.sv
module zbt_cmd_decode #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load_n,
  input  logic              rd_wrn,
  input  logic              sel_ok,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] adv_addr,
  output logic              cmd_vld,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_be_n,
  output logic [ADDR_W-1:0] cur_addr
);
  logic burst_act, burst_wr;
  logic do_load, do_dsel, do_adv;

  assign do_load = !load_n && sel_ok;
  assign do_dsel = !load_n && !sel_ok;
  assign do_adv  = load_n && burst_act;

  assign cmd_vld  = do_load || do_adv;
  assign cmd_wr   = do_load ? !rd_wrn : burst_wr;
  assign cmd_addr = do_load ? addr : adv_addr;
  assign cmd_be_n = lane_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_act <= 1'b0;
      burst_wr  <= 1'b0;
      cur_addr  <= '0;
    end else if (en) begin
      if (do_load) begin
        burst_act <= 1'b1;
        burst_wr  <= !rd_wrn;
        cur_addr  <= addr;
      end else if (do_dsel) begin
        burst_act <= 1'b0;
      end else if (do_adv) begin
        cur_addr  <= adv_addr;
      end
    end
  end

  // R5: an advance keeps the burst alive and its direction unchanged
  a_r5_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en && do_adv) |=> (burst_act && burst_wr == $past(burst_wr)));
  // R4: a deselect ends the burst
  a_r4_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
    (en && do_dsel) |=> !burst_act);
  // R1: a load records the port address
  a_r1_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (en && do_load) |=> (cur_addr == $past(addr)));
endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)  stg[i] <= '0;
        else if (en) stg[i] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)  stg[i] <= '0;
        else if (en) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        be_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdq,
  output logic                    oe
);
  logic [LANES*LANE_W-1:0] rd_word;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] mem_l [DEPTH];
    always_ff @(posedge clk)
      if (en && wr && !be_n[k]) mem_l[addr] <= wdata[k*LANE_W +: LANE_W];
    assign rd_word[k*LANE_W +: LANE_W] = mem_l[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe  <= 1'b0;
      rdq <= '0;
    end else if (en) begin
      oe <= rd;
      if (rd) rdq <= rd_word;
    end
  end
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = $clog2(DEPTH),
  parameter int unsigned LANES  = zbt_pkg::LANES_DEF,
  parameter int unsigned LANE_W = zbt_pkg::LANE_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke_n,
  input  logic                    cs_a_n,
  input  logic                    cs_b_n,
  input  logic                    cs_c,
  input  logic                    load_n,
  input  logic                    rd_wrn,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [ADDR_W-1:0]       adv_addr,
  output logic [ADDR_W-1:0]       cur_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int unsigned PW = 2 + ADDR_W + LANES;

  logic              en, sel_ok;
  logic              cmd_vld, cmd_wr;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_be_n;
  logic [PW-1:0]     ph_in, ph_out;
  logic              ph_vld, ph_wr;
  logic [ADDR_W-1:0] ph_addr;
  logic [LANES-1:0]  ph_be_n;
  logic              ph_read, ph_write;

  assign en     = !cke_n;
  assign sel_ok = !cs_a_n && !cs_b_n && cs_c;

  zbt_cmd_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(en), .load_n(load_n), .rd_wrn(rd_wrn),
    .sel_ok(sel_ok), .lane_we_n(lane_we_n), .addr(addr), .adv_addr(adv_addr),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
    .cmd_be_n(cmd_be_n), .cur_addr(cur_addr)
  );

  assign ph_in = {cmd_vld, cmd_wr, cmd_addr, cmd_be_n};

  zbt_pipe #(.W(PW), .STAGES(2)) u_pipe (
    .clk(clk), .rst_n(rst_n), .en(en), .din(ph_in), .dout(ph_out)
  );

  assign {ph_vld, ph_wr, ph_addr, ph_be_n} = ph_out;
  assign ph_read  = ph_vld && !ph_wr;
  assign ph_write = ph_vld && ph_wr;

  zbt_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .en(en), .wr(ph_write), .rd(ph_read),
    .addr(ph_addr), .be_n(ph_be_n), .wdata(wdata), .rdq(rdata), .oe(rdata_oe)
  );

  // R2: a read reaching its data phase drives the bus
  a_r2_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ph_read) |=> rdata_oe);
  // R8: a write data phase leaves the bus undriven
  a_r8_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ph_write) |=> !rdata_oe);
  // R4 / R6: an empty slot (deselect or no-op) leaves the bus undriven
  a_r4_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ph_vld) |=> !rdata_oe);
  // R3: a frozen edge changes nothing visible
  a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(rdata_oe) && $stable(rdata) && $stable(cur_addr)));
  // R9: the bus is idle on the first edge out of reset
  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rdata_oe);
endmodule

// File: tb/zbt_sram_core_test.sv
module zbt_sram_core_test;
  localparam int AW = 4;
  localparam int WW = 36;
  localparam logic [2:0] SEL_ON = 3'b001;   // {cs_a_n, cs_b_n, cs_c}

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke_n = 1'b0, load_n = 1'b1, rd_wrn = 1'b1;
  logic          cs_a_n = 1'b1, cs_b_n = 1'b1, cs_c = 1'b0;
  logic [3:0]    lane_we_n = 4'hF;
  logic [AW-1:0] addr = '0, adv_addr, cur_addr;
  logic [WW-1:0] wdata = '0, rdata;
  logic          rdata_oe;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  // Sequencer model: linear order wrapping within a group of four.
  assign adv_addr = {cur_addr[AW-1:2], cur_addr[1:0] + 2'd1};

  zbt_sram_core uut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .cs_c(cs_c), .load_n(load_n), .rd_wrn(rd_wrn), .lane_we_n(lane_we_n),
    .addr(addr), .adv_addr(adv_addr), .cur_addr(cur_addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [WW-1:0] merge(input logic [WW-1:0] old_w, input logic [WW-1:0] new_w,
                                          input logic [3:0] en_n);
    logic [WW-1:0] r = old_w;
    for (int k = 0; k < 4; k++) if (!en_n[k]) r[9*k +: 9] = new_w[9*k +: 9];
    return r;
  endfunction

  task automatic tick(input logic ck, input logic ld, input logic rw, input logic [2:0] sel,
                      input logic [3:0] be, input logic [AW-1:0] a, input logic [WW-1:0] wd);
    cke_n = ck; load_n = ld; rd_wrn = rw; {cs_a_n, cs_b_n, cs_c} = sel;
    lane_we_n = be; addr = a; wdata = wd;
    @(negedge clk);
  endtask

  task automatic ld(input logic rw, input logic [AW-1:0] a, input logic [3:0] be, input logic [WW-1:0] wd);
    tick(1'b0, 1'b0, rw, SEL_ON, be, a, wd);
  endtask
  task automatic adv(input logic rw, input logic [3:0] be, input logic [WW-1:0] wd);
    tick(1'b0, 1'b1, rw, SEL_ON, be, '0, wd);
  endtask
  task automatic dsel(input logic [WW-1:0] wd);
    tick(1'b0, 1'b0, 1'b1, 3'b000, 4'hF, '0, wd);
  endtask
  task automatic hold(input logic [WW-1:0] wd);
    tick(1'b1, 1'b0, 1'b0, SEL_ON, 4'h0, 4'd12, wd);
  endtask

  task automatic chk_oe(input string req, input logic exp);
    n_chk++;
    if (rdata_oe !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata_oe=%b expected %b", req, rdata_oe, exp);
    end
  endtask
  task automatic chk_rd(input string req, input logic [WW-1:0] exp);
    n_chk++;
    if (rdata_oe !== 1'b1 || rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: oe=%b rdata=%h expected oe=1 rdata=%h", req, rdata_oe, rdata, exp);
    end
  endtask
  task automatic chk_addr(input string req, input logic [AW-1:0] exp);
    n_chk++;
    if (cur_addr !== exp) begin
      n_bad++;
      $display("FAIL %s: cur_addr=%0d expected %0d", req, cur_addr, exp);
    end
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [3:0] be, input logic [WW-1:0] d);
    ld(1'b0, a, be, '0); dsel('0); dsel(d);
  endtask
  task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [WW-1:0] exp);
    ld(1'b1, a, 4'hF, '0); dsel('0); dsel('0);
    chk_rd(req, exp);
  endtask

  // R9: reset state
  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_oe("R9 oe during reset", 1'b0);
    rst_n = 1'b1;
    dsel('0);
    chk_oe("R9 oe after first edge", 1'b0);
    adv(1'b1, 4'hF, '0); dsel('0); dsel('0);
    chk_oe("R9 no burst after reset", 1'b0);
  endtask

  // R10, R2, R8, R6: write then read two cycles later, fillers around it
  task automatic t_raw;
    ld(1'b0, 4'd5, 4'h0, '0);
    dsel('0);
    ld(1'b1, 4'd5, 4'hF, 36'h5A5A5A5A5);
    chk_oe("R8 write phase quiet", 1'b0);
    dsel('0);
    chk_oe("R4 deselect phase quiet", 1'b0);
    adv(1'b1, 4'hF, '0);                 // no burst active: no-op
    chk_rd("R10 read after write", 36'h5A5A5A5A5);
    dsel('0);
    dsel('0);
    chk_oe("R6 no-op phase quiet", 1'b0);
  endtask

  // R2: back-to-back alternating writes and reads
  task automatic t_interleave;
    ld(1'b0, 4'd1, 4'h0, '0);
    ld(1'b1, 4'd5, 4'hF, '0);
    ld(1'b0, 4'd2, 4'h0, 36'h111111111);
    ld(1'b1, 4'd1, 4'hF, '0);
    chk_rd("R2 read A5 in stream", 36'h5A5A5A5A5);
    dsel(36'h222222222);
    chk_oe("R2 write A2 phase quiet", 1'b0);
    dsel('0);
    chk_rd("R2 read A1 in stream", 36'h111111111);
    dsel('0);
    rd_check("R2 read A2", 4'd2, 36'h222222222);
  endtask

  // R7, R8: lane writes and lane enables ignored on reads
  task automatic t_lanes;
    logic [WW-1:0] exp = merge('0, '1, 4'b1010);
    wr_word(4'd7, 4'h0, '0);
    wr_word(4'd7, 4'b1010, '1);
    ld(1'b1, 4'd7, 4'h0, '0); dsel('0); dsel('1);
    chk_rd("R7 lanes 0 and 2 written", exp);
    rd_check("R8 read enables ignored", 4'd7, exp);
    wr_word(4'd7, 4'b0111, 36'hABCDEF012);
    exp = merge(exp, 36'hABCDEF012, 4'b0111);
    rd_check("R7 lane 3 alone", 4'd7, exp);
  endtask

  // R5, R1: burst write then wrapped burst read with rd_wrn flipped
  task automatic t_burst;
    ld(1'b0, 4'd8, 4'h0, '0);
    adv(1'b1, 4'h0, '0);
    adv(1'b1, 4'h0, 36'h000000A00);
    adv(1'b1, 4'h0, 36'h000000A01);
    dsel(36'h000000A02);
    dsel(36'h000000A03);
    ld(1'b1, 4'd9, 4'h0, '0);
    chk_addr("R1 load captures address", 4'd9);
    adv(1'b0, 4'h0, '1);
    adv(1'b0, 4'h0, '1);
    chk_rd("R5 burst read first", 36'h000000A01);
    adv(1'b0, 4'h0, '1);
    chk_rd("R5 burst read second", 36'h000000A02);
    chk_addr("R5 wrap address", 4'd8);
    dsel('1);
    chk_rd("R5 burst read third", 36'h000000A03);
    dsel('1);
    chk_rd("R5 burst read wrapped", 36'h000000A00);
    dsel('0);
    chk_oe("R4 after burst", 1'b0);
    rd_check("R5 rd_wrn ignored on advance", 4'd10, 36'h000000A02);
  endtask

  // R3: freeze between command and data phase
  task automatic t_freeze;
    wr_word(4'd12, 4'h0, 36'hC0FFEE123);
    ld(1'b1, 4'd12, 4'hF, '0);
    hold('1);
    dsel('0);
    chk_oe("R3 frozen edge not counted", 1'b0);
    dsel('0);
    chk_rd("R3 phase slips by one", 36'hC0FFEE123);
    hold('1);
    chk_rd("R3 output held", 36'hC0FFEE123);
    dsel('0);
    chk_oe("R3 resumes", 1'b0);
    rd_check("R3 frozen write ignored", 4'd12, 36'hC0FFEE123);
  endtask

  // R4, R1: deselect mid-burst, load blocked by one select
  task automatic t_deselect;
    ld(1'b1, 4'd8, 4'hF, '0);
    tick(1'b0, 1'b0, 1'b1, 3'b101, 4'hF, 4'd9, '0);   // cs_a_n false
    adv(1'b1, 4'hF, '0);
    chk_rd("R4 in-flight read completes", 36'h000000A00);
    dsel('0);
    chk_oe("R4 deselect phase quiet", 1'b0);
    dsel('0);
    chk_oe("R4 burst terminated", 1'b0);
    tick(1'b0, 1'b0, 1'b1, 3'b000, 4'hF, 4'd8, '0);   // cs_c false
    tick(1'b0, 1'b0, 1'b1, 3'b011, 4'hF, 4'd8, '0);   // cs_b_n false
    dsel('0);
    chk_oe("R1 cs_c low blocks load", 1'b0);
    dsel('0);
    chk_oe("R1 cs_b_n high blocks load", 1'b0);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_raw();
    t_interleave();
    t_lanes();
    t_burst();
    t_freeze();
    t_deselect();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule